// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block gathers a bank of external interrupt wires and turns each one into a clean, active-high level request for a parent interrupt controller. Every line is synchronised into the local clock with two flops. It is then sensed as a level or as an edge, of either polarity. The result is held in a per-line request bit and gated by a per-line mask before it reaches its own output pin. Each line has two independent configuration bits: one sets polarity, the other chooses edge or level sensing. Whatever the input sense, every output is high while its request is pending and unmasked.

Software reaches the unit over a plain synchronous register port with byte offsets, one bit per line in every register. A write takes effect at the clock edge where it is presented. A read returns its data on `bus_rdata` one cycle later. The port carries control and status only, so it has no valid/ready handshake: a selected access always completes in one cycle. Edge requests stay latched until software writes a one to the line's bit in the clear register. A request taken while the line is masked is therefore still pending when the mask is lifted. Two further registers, for source selection and software interrupts, are plain storage only.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the mask register (0x00) reads all ones, and the polarity (0x14), edge-select (0x18), source-select (0x04) and software-interrupt (0x1C) registers read zero. Every output is low.
- R2: The registers at 0x00, 0x04, 0x14, 0x18 and 0x1C read back the last value written to them. Read data appears on `bus_rdata` one cycle after the read is presented.
- R3: Each output equals its line's request ANDed with the inverse of its mask bit. A mask bit of 1 forces the output low, and a mask bit of 0 passes the request.
- R4: Offset 0x0C reads the request bits before masking. Offset 0x08 reads the request bits ANDed with the inverse of the mask.
- R5: With edge-select 1 and polarity 1, a rising input sets the request. The request stays set after the input falls again.
- R6: With edge-select 1 and polarity 0, a falling input sets the request. A rising input does not set it.
- R7: Writing 1 to a bit at offset 0x10 clears that line's latched edge request. Bits written as 0 leave their requests unchanged, and a read of 0x10 returns zero.
- R8: With edge-select 0, the request follows the input when polarity is 1 and the inverted input when polarity is 0. A clear has no lasting effect while that level is still asserted.
- R9: A request latched while its line is masked stays pending. It drives the output as soon as the mask bit is cleared.
- R10: When a line's selected edge and a clear of that line fall in the same cycle, the request ends up set.
- R11: An input change reaches the request and output after the third rising clock edge following it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | NUM_LINES (32) | Write data |
| bus_rdata | output | NUM_LINES (32) | Read data, one cycle after the read |
| irq_in | input | NUM_LINES (32) | Asynchronous external interrupt inputs |
| irq_out | output | NUM_LINES (32) | Active-high level requests to the parent controller |

## Verification
The two functions that can coincide are a clear written by software and a freshly detected edge on the same line. The bench changes an input so that its detection edge lands exactly on the clock edge that carries a clear write for that line. In the same write it clears a second line whose request was already pending. The request of the edge line must read back as set, and the second line must read back as cleared. A near-exhaustive sweep of mixed edge and level configurations across all 32 lines covers the other combinations against an arithmetic model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam logic [7:0] OFS_MASK   = 8'h00;
  localparam logic [7:0] OFS_SRCSEL = 8'h04;
  localparam logic [7:0] OFS_MSTAT  = 8'h08;
  localparam logic [7:0] OFS_RSTAT  = 8'h0C;
  localparam logic [7:0] OFS_CLR    = 8'h10;
  localparam logic [7:0] OFS_POL    = 8'h14;
  localparam logic [7:0] OFS_EDGE   = 8'h18;
  localparam logic [7:0] OFS_SOFT   = 8'h1C;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic pol_high,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic prev_q;
  logic req_q;
  logic norm_now;
  logic norm_prev;
  logic hit;

  assign norm_now  = pol_high ? sync_in : ~sync_in;
  assign norm_prev = pol_high ? prev_q  : ~prev_q;
  assign hit       = norm_now & ~norm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= sync_in;
      if (edge_mode) begin
        if (hit)      req_q <= 1'b1;
        else if (clr) req_q <= 1'b0;
      end else begin
        req_q <= norm_now;
      end
    end
  end

  assign req = req_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && hit) |=> req_q); // R10
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && clr && !hit) |=> !req_q); // R7
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && req_q && !clr) |=> req_q); // R9
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import ext_irq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      req_raw,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      edge_o,
  output logic [N-1:0]      clr_o
);
  logic [N-1:0] mask_q, srcsel_q, pol_q, edge_q, soft_q, rdata_q;
  logic         wr_hit, rd_hit, mask_wr;
  logic [N-1:0] masked;

  assign wr_hit  = bus_sel & bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign mask_wr = wr_hit && (bus_addr == OFS_MASK[ADDR_W-1:0]);
  assign masked  = req_raw & ~mask_q;
  assign clr_o   = (wr_hit && bus_addr == OFS_CLR[ADDR_W-1:0]) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      srcsel_q <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
      soft_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata;
      if (wr_hit && bus_addr == OFS_SRCSEL[ADDR_W-1:0]) srcsel_q <= bus_wdata;
      if (wr_hit && bus_addr == OFS_POL[ADDR_W-1:0])    pol_q    <= bus_wdata;
      if (wr_hit && bus_addr == OFS_EDGE[ADDR_W-1:0])   edge_q   <= bus_wdata;
      if (wr_hit && bus_addr == OFS_SOFT[ADDR_W-1:0])   soft_q   <= bus_wdata;
      if (rd_hit) begin
        unique case (bus_addr)
          OFS_MASK[ADDR_W-1:0]:   rdata_q <= mask_q;
          OFS_SRCSEL[ADDR_W-1:0]: rdata_q <= srcsel_q;
          OFS_MSTAT[ADDR_W-1:0]:  rdata_q <= masked;
          OFS_RSTAT[ADDR_W-1:0]:  rdata_q <= req_raw;
          OFS_POL[ADDR_W-1:0]:    rdata_q <= pol_q;
          OFS_EDGE[ADDR_W-1:0]:   rdata_q <= edge_q;
          OFS_SOFT[ADDR_W-1:0]:   rdata_q <= soft_q;
          default:                rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q;
  assign pol_o     = pol_q;
  assign edge_o    = edge_q;

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R2
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] sync_v, req_v, mask_v, pol_v, edge_v, clr_v;
  logic                 mask_wr;

  irq_sync_bank #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_v)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line_sense u_line (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_v[i]), .pol_high(pol_v[i]),
      .edge_mode(edge_v[i]), .clr(clr_v[i]), .req(req_v[i])
    );
  end

  irq_regs #(.N(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_raw(req_v), .mask_o(mask_v), .pol_o(pol_v), .edge_o(edge_v),
    .clr_o(clr_v)
  );

  assign irq_out = req_v & ~mask_v;

  assign mask_wr = bus_sel && bus_wr && (bus_addr == ext_irq_pkg::OFS_MASK[ADDR_W-1:0]);

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> ((irq_out & $past(bus_wdata)) == '0)); // R3
endmodule

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, irq_in = '0;
  logic [31:0] bus_rdata, irq_out;
  int checks = 0, errors = 0;

  ext_irq_sense uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a[4:0]; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a[4:0];
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] norm(input logic [31:0] v, input logic [31:0] p);
    return (v & p) | (~v & ~p);
  endfunction

  logic [31:0] r, pol, edg, exp_req, old_in, nv, hits, msk;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 irq_out after reset", irq_out, 32'h0);
    rd(8'h00, r); check("R1 mask reset", r, 32'hFFFF_FFFF);
    rd(8'h14, r); check("R1 polarity reset", r, 32'h0);
    rd(8'h18, r); check("R1 edge reset", r, 32'h0);
    rd(8'h04, r); check("R1 srcsel reset", r, 32'h0);
    rd(8'h1C, r); check("R1 soft reset", r, 32'h0);
    rd(8'h0C, r); check("R8 low level lines pending after reset", r, 32'hFFFF_FFFF);

    // R2 storage sweep
    for (int k = 0; k < 4; k++) begin
      automatic logic [31:0] v = 32'h1357_9BDF * (k + 1) ^ (32'hF0 << k);
      wr(8'h04, v);  rd(8'h04, r); check("R2 srcsel readback", r, v);
      wr(8'h1C, ~v); rd(8'h1C, r); check("R2 soft readback", r, ~v);
      wr(8'h14, v ^ 32'h5A5A_5A5A); rd(8'h14, r); check("R2 polarity readback", r, v ^ 32'h5A5A_5A5A);
      wr(8'h18, v + 32'd7);         rd(8'h18, r); check("R2 edge readback", r, v + 32'd7);
      wr(8'h00, v);                 rd(8'h00, r); check("R2 mask readback", r, v);
    end
    rd(8'h10, r); check("R7 clear reads zero", r, 32'h0);

    // main sweep, mixed configuration
    pol = 32'hA5C3_3C5A; edg = 32'h0FF0_6996;
    wr(8'h14, pol); wr(8'h18, edg); wr(8'h00, 32'h0);
    irq_in = 32'h0; settle();
    wr(8'h10, 32'hFFFF_FFFF); settle();
    exp_req = ~edg & norm(irq_in, pol);
    old_in = irq_in;
    rd(8'h0C, r); check("R8 level after clear", r, exp_req);
    for (int s = 1; s <= 24; s++) begin
      @(negedge clk);
      nv = (32'h9E37_79B9 * s) ^ (32'h3 << (s % 30));
      irq_in = nv;
      settle();
      hits = norm(nv, pol) & ~norm(old_in, pol);
      exp_req = (edg & (exp_req | hits)) | (~edg & norm(nv, pol));
      old_in = nv;
      rd(8'h0C, r); check("R5 R6 R8 raw status sweep", r, exp_req);
      check("R3 output sweep", irq_out, exp_req);
      if (s % 3 == 0) begin
        automatic logic [31:0] c = 32'hC0DE_0F0F ^ (s * 32'h0101_0101);
        wr(8'h10, c); settle();
        exp_req = exp_req & ~(edg & c);
        rd(8'h0C, r); check("R7 R8 partial clear", r, exp_req);
      end
    end

    // masking
    msk = 32'h3333_CCCC;
    wr(8'h00, msk); @(negedge clk);
    check("R3 masked output", irq_out, exp_req & ~msk);
    rd(8'h08, r); check("R4 masked status", r, exp_req & ~msk);
    rd(8'h0C, r); check("R4 raw status under mask", r, exp_req);

    // R9 edge latched while masked
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF);
    irq_in = 32'h0; settle();
    wr(8'h10, 32'hFFFF_FFFF);
    @(negedge clk) irq_in = 32'h0000_00F0; settle();
    @(negedge clk) irq_in = 32'h0; settle();
    check("R9 masked output low", irq_out, 32'h0);
    wr(8'h00, 32'h0); @(negedge clk);
    check("R9 pending after unmask", irq_out, 32'h0000_00F0);
    check("R5 rising edge held", irq_out[4], 1'b1);

    // R6 falling edge on line 9
    wr(8'h14, 32'hFFFF_FDFF);
    @(negedge clk) irq_in = 32'h0000_0200; settle();
    check("R6 rise ignored on falling line", irq_out[9], 1'b0);
    @(negedge clk) irq_in = 32'h0; settle();
    check("R6 fall sets", irq_out[9], 1'b1);
    wr(8'h10, 32'h0000_0010); settle();
    check("R7 selective clear", irq_out, 32'h0000_02E0);

    // R11 latency on line 0 (rising edge)
    wr(8'h10, 32'hFFFF_FFFF); settle();
    @(negedge clk) irq_in = 32'h1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 not after second edge", irq_out[0], 1'b0);
    @(posedge clk); @(negedge clk);
    check("R11 after third edge", irq_out[0], 1'b1);

    // R10 coincident edge and clear on line 1, plus pending line 0
    @(negedge clk) irq_in = 32'h3;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'h10; bus_wdata = 32'h3;
    @(posedge clk);
    @(negedge clk) bus_sel = 0; bus_wr = 0;
    settle();
    rd(8'h0C, r); check("R10 set wins over clear", r & 32'h3, 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got %h expected %h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule